// File: doc/BRIEF.md
# Dual-Core Interrupt Distributor

This block gathers interrupt requests from shared peripherals, from private per-core sources and from software, and hands each of two processor cores the most urgent request that core may take. Every interrupt has a fixed number in a 96-entry map: 0..15 are software-raised, 27, 29 and 30 are per-core timer and watchdog lines, and 32..95 are shared peripheral lines. The numbers 16..26, 28 and 31 never take part in arbitration.

A single write port carries four operations, selected by the two top address bits. The low eight address bits name an interrupt number. The operations are: source configuration (priority, edge or level, shared routing), per-core enable, software raise, and end-of-interrupt. Each core has an IRQ output and an ID output, and an acknowledge strobe. The acknowledge takes the ID shown at that moment and marks it active for that core. Two lines per core from programmable logic, the fast and the normal request, go straight to the core's request outputs without arbitration.

Top module: `irq_distributor`

## Requirements
- R1: After reset every source is disabled, level-sensitive, priority 0, routed to no core and not pending. Every `irq_id_o` field reads 255, the no-interrupt code, and `irq_o` and `fiq_o` are low.
- R2: IDs 0..15 become pending only through a write with op 2 (address bits [9:8] = 2), where the low address byte gives the ID. Data bit c marks core c. Software-raised IDs always behave as edge sources.
- R3: IDs 16..26, 28 and 31 are never presented on `irq_id_o`, whatever is written, and a software-raise write naming an ID of 16 or more has no effect.
- R4: Core c's private inputs are `ppi_i[3c]` for ID 27, `ppi_i[3c+1]` for ID 29 and `ppi_i[3c+2]` for ID 30. They reach only core c.
- R5: Shared ID n (32..95) is driven by `spi_i[n-32]` and is presented to core c only while target bit c is set. The target field is bits [6:5] of an op 0 write, with bit 5 for core 0 and bit 6 for core 1.
- R6: A source is presented to core c only when its enable bit for core c is set. The enable is set by an op 1 write, with data bit c for core c, and the two cores' enables are independent.
- R7: Data bit 4 of an op 0 write selects edge (1) or level (0). An edge source latches pending on a rising input and clears on acknowledge. A level source is pending exactly while its input is high.
- R8: Among the eligible sources of a core, the lowest priority value wins. The priority is data bits [3:0] of an op 0 write. On equal priority the lower ID wins. The winner shows on that core's `irq_id_o` field, and no eligible source gives 255.
- R9: An acknowledge for core c while an ID is shown makes that ID active for core c. An active ID is not shown to core c again until its end-of-interrupt. The other core is unaffected.
- R10: A write with op 3 and data bit 0 = c ends the active state of the addressed ID on core c. The ID is shown again if it is still pending.
- R11: `fiq_o[c]` follows `pl_fiq_i[c]`. `irq_o[c]` is high when core c has an arbitrated interrupt or `pl_irq_i[c]` is high. The bypass lines never change `irq_id_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_i | input | 64 | Shared peripheral request lines, IDs 32..95 |
| ppi_i | input | 6 | Private lines, three per core |
| pl_fiq_i | input | 2 | Fast request from logic, one per core |
| pl_irq_i | input | 2 | Normal request from logic, one per core |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 10 | Op in [9:8], interrupt ID in [7:0] |
| wr_data_i | input | 7 | Write data |
| ack_i | input | 2 | Acknowledge strobe per core |
| irq_o | output | 2 | Interrupt request per core |
| fiq_o | output | 2 | Fast interrupt request per core |
| irq_id_o | output | 16 | Presented ID per core, core c in bits [8c+7:8c] |

## Verification
The hardest state to reach is an edge source that fires again while it is active on one core and routed to the other. The new pending bit must then stay hidden until the end-of-interrupt on the first core, and it must be visible at once on the second. Random stimulus gets there by giving every source a priority from a narrow range, so that equal priorities are common. It also toggles shared and private lines, raises software interrupts, acknowledges on random cycles and sends end-of-interrupt writes for the last ID each core took. Directed steps before the random run walk through re-raise while active, level drop after release, and target removal.

// File: rtl/idist_pkg.sv
package idist_pkg;
  localparam int NUM_CORES    = 2;
  localparam int NUM_SGI      = 16;
  localparam int SPI_BASE     = 32;
  localparam int PPI_PER_CORE = 3;
  localparam int ID_GTIMER    = 27;
  localparam int ID_PTIMER    = 29;
  localparam int ID_WDOG      = 30;

  typedef enum logic [1:0] {OP_CFG = 2'd0, OP_EN = 2'd1, OP_SGI = 2'd2, OP_EOI = 2'd3} op_e;

  function automatic int ppi_id(int k);
    case (k)
      0:       return ID_GTIMER;
      1:       return ID_PTIMER;
      default: return ID_WDOG;
    endcase
  endfunction

  function automatic logic id_usable(int i, int num_id);
    return (i < NUM_SGI) || (i == ID_GTIMER) || (i == ID_PTIMER) || (i == ID_WDOG)
        || (i >= SPI_BASE && i < num_id);
  endfunction
endpackage

// File: rtl/idist_pend.sv
module idist_pend #(
  parameter int NUM_ID = 96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_ID-1:0] src_i,
  input  logic [NUM_ID-1:0] edge_i,
  input  logic [NUM_ID-1:0] usable_i,
  input  logic [NUM_ID-1:0] sgi_set_i,
  input  logic [NUM_ID-1:0] ack_hit_i,
  input  logic [NUM_ID-1:0] eoi_hit_i,
  output logic [NUM_ID-1:0] pend_o,
  output logic [NUM_ID-1:0] act_o
);
  logic [NUM_ID-1:0] prev_q, latch_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      latch_q <= '0;
      act_q   <= '0;
    end else begin
      prev_q  <= src_i;
      // a fresh edge in the acknowledge cycle survives the clear
      latch_q <= (latch_q & ~ack_hit_i) | (src_i & ~prev_q) | sgi_set_i;
      act_q   <= (act_q & ~eoi_hit_i) | ack_hit_i;
    end
  end

  assign pend_o = usable_i & ((edge_i & latch_q) | (~edge_i & src_i));
  assign act_o  = act_q;
endmodule

// File: rtl/idist_arb.sv
module idist_arb #(
  parameter int NUM_ID = 96,
  parameter int PRIO_W = 4,
  parameter int ID_W   = 8
) (
  input  logic [NUM_ID-1:0]             cand_i,
  input  logic [NUM_ID-1:0][PRIO_W-1:0] prio_i,
  output logic                          valid_o,
  output logic [ID_W-1:0]               id_o
);
  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict compare: equal priority keeps the lower ID
  always_comb begin
    valid_o = 1'b0;
    id_o    = '1;
    best_p  = '1;
    for (int i = 0; i < NUM_ID; i++) begin
      if (cand_i[i] && (!valid_o || prio_i[i] < best_p)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
        best_p  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import idist_pkg::*;
#(
  parameter int  NUM_SPI = 64,
  parameter int  PRIO_W  = 4,
  parameter int  ID_W    = 8,
  localparam int NUM_ID  = SPI_BASE + NUM_SPI,
  localparam int DATA_W  = PRIO_W + 1 + NUM_CORES,
  localparam int ADDR_W  = ID_W + 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SPI-1:0]        spi_i,
  input  logic [NUM_CORES*PPI_PER_CORE-1:0] ppi_i,
  input  logic [NUM_CORES-1:0]      pl_fiq_i,
  input  logic [NUM_CORES-1:0]      pl_irq_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic [NUM_CORES-1:0]      ack_i,
  output logic [NUM_CORES-1:0]      irq_o,
  output logic [NUM_CORES-1:0]      fiq_o,
  output logic [NUM_CORES*ID_W-1:0] irq_id_o
);
  localparam int EDGE_BIT = PRIO_W;

  op_e             op;
  logic [ID_W-1:0] wid;
  assign op  = op_e'(wr_addr_i[ADDR_W-1 -: 2]);
  assign wid = wr_addr_i[ID_W-1:0];

  logic [NUM_ID-1:0][PRIO_W-1:0]    prio_q;
  logic [NUM_ID-1:0]                edge_q;
  logic [NUM_ID-1:0][NUM_CORES-1:0] tgt_q;
  logic [NUM_CORES-1:0][NUM_ID-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      edge_q <= '0;
      tgt_q  <= '0;
      en_q   <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_ID; i++) begin
        if (wid == ID_W'(i)) begin
          if (op == OP_CFG) begin
            prio_q[i] <= wr_data_i[PRIO_W-1:0];
            edge_q[i] <= wr_data_i[EDGE_BIT];
            tgt_q[i]  <= wr_data_i[DATA_W-1 -: NUM_CORES];
          end
          if (op == OP_EN) begin
            for (int c = 0; c < NUM_CORES; c++) en_q[c][i] <= wr_data_i[c];
          end
        end
      end
    end
  end

  logic [NUM_ID-1:0] usable, edge_eff;
  always_comb begin
    for (int i = 0; i < NUM_ID; i++) begin
      usable[i]   = id_usable(i, NUM_ID);
      edge_eff[i] = (i < NUM_SGI) ? 1'b1 : edge_q[i];
    end
  end

  logic [NUM_CORES-1:0][NUM_ID-1:0] pend_w, act_w;
  logic [NUM_CORES-1:0]             arb_valid;
  logic [NUM_CORES-1:0][ID_W-1:0]   arb_id;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_ID-1:0] src, sgi_set, ack_hit, eoi_hit, route, cand;

    always_comb begin
      src     = '0;
      sgi_set = '0;
      ack_hit = '0;
      eoi_hit = '0;
      route   = '1;
      for (int i = SPI_BASE; i < NUM_ID; i++) begin
        src[i]   = spi_i[i-SPI_BASE];
        route[i] = tgt_q[i][c];
      end
      for (int k = 0; k < PPI_PER_CORE; k++) src[ppi_id(k)] = ppi_i[c*PPI_PER_CORE+k];
      for (int i = 0; i < NUM_ID; i++) begin
        if (wr_en_i && wid == ID_W'(i)) begin
          sgi_set[i] = (i < NUM_SGI) && (op == OP_SGI) && wr_data_i[c];
          eoi_hit[i] = (op == OP_EOI) && (wr_data_i[0] == 1'(c));
        end
        ack_hit[i] = ack_i[c] && arb_valid[c] && (arb_id[c] == ID_W'(i));
      end
    end

    idist_pend #(.NUM_ID(NUM_ID)) u_pend (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src),
      .edge_i    (edge_eff),
      .usable_i  (usable),
      .sgi_set_i (sgi_set),
      .ack_hit_i (ack_hit),
      .eoi_hit_i (eoi_hit),
      .pend_o    (pend_w[c]),
      .act_o     (act_w[c])
    );

    assign cand = pend_w[c] & route & en_q[c] & ~act_w[c];

    idist_arb #(.NUM_ID(NUM_ID), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .cand_i  (cand),
      .prio_i  (prio_q),
      .valid_o (arb_valid[c]),
      .id_o    (arb_id[c])
    );

    assign irq_o[c]               = arb_valid[c] | pl_irq_i[c];
    assign fiq_o[c]               = pl_fiq_i[c];
    assign irq_id_o[c*ID_W +: ID_W] = arb_id[c];
  end
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk
  import idist_pkg::*;
#(
  parameter int NUM_ID = 96,
  parameter int ID_W   = 8,
  parameter int DATA_W = 7,
  parameter int ADDR_W = 10
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             wr_en_i,
  input logic [ADDR_W-1:0]                wr_addr_i,
  input logic [DATA_W-1:0]                wr_data_i,
  input logic [NUM_CORES-1:0]             ack_i,
  input logic [NUM_CORES-1:0]             arb_valid,
  input logic [NUM_CORES-1:0][ID_W-1:0]   arb_id,
  input logic [NUM_CORES-1:0][NUM_ID-1:0] en_q,
  input logic [NUM_ID-1:0][NUM_CORES-1:0] tgt_q,
  input logic [NUM_CORES-1:0][NUM_ID-1:0] pend_w
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
    logic eoi_c, res_id;
    assign eoi_c  = wr_en_i && (wr_addr_i[ADDR_W-1 -: 2] == OP_EOI) && (wr_data_i[0] == 1'(c));
    assign res_id = (arb_id[c] >= ID_W'(NUM_SGI) && arb_id[c] < ID_W'(ID_GTIMER))
                 || arb_id[c] == ID_W'(28) || arb_id[c] == ID_W'(31);

    a_r3_reserved_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arb_valid[c] |-> !res_id);

    a_r6_enabled_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arb_valid[c] |-> en_q[c][arb_id[c]]);

    a_r5_routed_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arb_valid[c] && arb_id[c] >= ID_W'(SPI_BASE)) |-> tgt_q[arb_id[c]][c]);

    a_r9_active_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[c] && arb_valid[c] && !eoi_c) |=> !(arb_valid[c] && arb_id[c] == $past(arb_id[c])));

    for (genvar i = 0; i < NUM_SGI; i++) begin : g_sgi
      a_r2_sgi_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_w[c][i]) |-> $past(wr_en_i && wr_addr_i[ADDR_W-1 -: 2] == OP_SGI
                                      && wr_addr_i[ID_W-1:0] == ID_W'(i) && wr_data_i[c]));
    end
  end
endmodule

bind irq_distributor irq_distributor_chk #(
  .NUM_ID(NUM_ID), .ID_W(ID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .ack_i     (ack_i),
  .arb_valid (arb_valid),
  .arb_id    (arb_id),
  .en_q      (en_q),
  .tgt_q     (tgt_q),
  .pend_w    (pend_w)
);

// File: tb/irq_distributor_test.sv
module irq_distributor_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [63:0] spi = '0;
  logic [5:0]  ppi = '0;
  logic [1:0]  pl_fiq = '0, pl_irq = '0, ack = '0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [6:0]  wr_data = '0;
  logic [1:0]  irq_o, fiq_o;
  logic [15:0] irq_id_o;

  irq_distributor uut (
    .clk_i(clk), .rst_ni(rst_n), .spi_i(spi), .ppi_i(ppi), .pl_fiq_i(pl_fiq),
    .pl_irq_i(pl_irq), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ack_i(ack), .irq_o(irq_o), .fiq_o(fiq_o), .irq_id_o(irq_id_o)
  );

  always #10ns clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int prio_m[96];
  bit edge_m[96];
  bit [1:0] tgt_m[96];
  bit en_m[2][96], pe_m[2][96], act_m[2][96], prev_m[2][96];
  int last_ack[2];

  function automatic bit vid(int i);
    return i < 16 || i == 27 || i == 29 || i == 30 || (i >= 32 && i < 96);
  endfunction

  function automatic bit srcm(int c, int i);
    if (i >= 32) return spi[i-32];
    if (i == 27) return ppi[3*c];
    if (i == 29) return ppi[3*c+1];
    if (i == 30) return ppi[3*c+2];
    return 1'b0;
  endfunction

  function automatic bit elig(int c, int i);
    bit p;
    if (!vid(i)) return 1'b0;
    p = (i < 16 || edge_m[i]) ? pe_m[c][i] : srcm(c, i);
    if (i >= 32) p = p & tgt_m[i][c];
    return p && en_m[c][i] && !act_m[c][i];
  endfunction

  function automatic int best(int c);
    int b = 255, bp = 99;
    for (int i = 0; i < 96; i++)
      if (elig(c, i) && prio_m[i] < bp) begin b = i; bp = prio_m[i]; end
    return b;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 96; i++) begin
      prio_m[i] = 0; edge_m[i] = 0; tgt_m[i] = 0;
      for (int c = 0; c < 2; c++) begin
        en_m[c][i] = 0; pe_m[c][i] = 0; act_m[c][i] = 0; prev_m[c][i] = 0;
      end
    end
    last_ack = '{0, 0};
  endtask

  task automatic model_update();
    int b[2];
    int op, wid;
    b[0] = best(0); b[1] = best(1);
    op = int'(wr_addr[9:8]); wid = int'(wr_addr[7:0]);
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 96; i++) begin
        bit s, clr, sg, eh;
        s   = srcm(c, i);
        clr = ack[c] && b[c] != 255 && b[c] == i;
        sg  = wr_en && op == 2 && wid == i && i < 16 && wr_data[c];
        eh  = wr_en && op == 3 && wid == i && int'(wr_data[0]) == c;
        pe_m[c][i]   = (pe_m[c][i] & !clr) | (s & !prev_m[c][i]) | sg;
        act_m[c][i]  = (act_m[c][i] & !eh) | clr;
        prev_m[c][i] = s;
      end
      if (ack[c] && b[c] != 255) last_ack[c] = b[c];
    end
    if (wr_en && wid < 96) begin
      if (op == 0) begin
        prio_m[wid] = int'(wr_data[3:0]); edge_m[wid] = wr_data[4]; tgt_m[wid] = wr_data[6:5];
      end
      if (op == 1) begin en_m[0][wid] = wr_data[0]; en_m[1][wid] = wr_data[1]; end
    end
  endtask

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    for (int c = 0; c < 2; c++) begin
      int eb = best(c);
      chk("R8", $sformatf("core%0d irq_id", c), int'(irq_id_o[c*8 +: 8]), eb);
      chk("R11", $sformatf("core%0d irq", c), int'(irq_o[c]), int'(eb != 255 || pl_irq[c]));
      chk("R11", $sformatf("core%0d fiq", c), int'(fiq_o[c]), int'(pl_fiq[c]));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    wr_en = 1'b0;
    ack   = '0;
  endtask

  task automatic wr(int op, int id, int d);
    wr_en = 1'b1; wr_addr = {2'(op), 8'(id)}; wr_data = 7'(d);
    tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; spi = '0; ppi = '0; pl_fiq = '0; pl_irq = '0; ack = '0; wr_en = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int idv(int c);
    return int'(irq_id_o[c*8 +: 8]);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #4000000ns;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    chk("R1", "irq_o", int'(irq_o), 0);
    chk("R1", "fiq_o", int'(fiq_o), 0);
    chk("R1", "core0 id", idv(0), 255);
    chk("R1", "core1 id", idv(1), 255);
    // R11 bypass lines
    pl_fiq = 2'b01; pl_irq = 2'b10; tick();
    chk("R11", "fiq_o", int'(fiq_o), 1);
    chk("R11", "irq_o", int'(irq_o), 2);
    chk("R11", "core1 id", idv(1), 255);
    pl_fiq = '0; pl_irq = '0; tick();
    // R2/R6 software raise with enable only on core1
    wr(1, 5, 2);
    wr(2, 5, 3);
    chk("R2", "core1 id", idv(1), 5);
    chk("R6", "core0 id", idv(0), 255);
    // R3 reserved ID
    wr(1, 20, 3);
    wr(2, 20, 3);
    chk("R3", "core0 id", idv(0), 255);
    chk("R3", "core1 id", idv(1), 5);
    // R9 acknowledge hides, R10 end-of-interrupt releases
    ack = 2'b10; tick();
    chk("R9", "core1 id after ack", idv(1), 255);
    wr(2, 5, 2);
    chk("R9", "core1 id re-raised while active", idv(1), 255);
    wr(3, 5, 1);
    chk("R10", "core1 id after eoi", idv(1), 5);
    ack = 2'b10; tick();
    wr(3, 5, 1);
    chk("R7", "edge consumed by ack", idv(1), 255);
    // R4 private line reaches only its core
    wr(1, 27, 3);
    wr(0, 27, 3);
    ppi = 6'b000001; tick();
    chk("R4", "core0 id", idv(0), 27);
    chk("R4", "core1 id", idv(1), 255);
    // R8 tie and priority, R5 routing
    wr(0, 40, 99);
    wr(1, 40, 3);
    spi[8] = 1'b1; tick();
    chk("R8", "tie goes to lower id", idv(0), 27);
    chk("R5", "core1 routed", idv(1), 40);
    wr(0, 40, 98);
    chk("R8", "lower value wins", idv(0), 40);
    wr(0, 40, 34);
    chk("R5", "core1 unrouted", idv(1), 255);
    chk("R5", "core0 routed", idv(0), 40);
    // R7 level source
    ack = 2'b01; tick();
    chk("R9", "core0 falls back", idv(0), 27);
    wr(3, 40, 0);
    chk("R7", "level still high", idv(0), 40);
    spi[8] = 1'b0; tick();
    chk("R7", "level dropped", idv(0), 27);

    // random phase
    do_reset();
    for (int i = 0; i < 96; i++) begin
      wr(0, i, $urandom_range(0, 3) | ($urandom_range(0, 1) << 4) | ($urandom_range(0, 3) << 5));
      wr(1, i, $urandom_range(0, 3));
    end
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 9);
      if (r == 0) begin
        wr_en = 1'b1; wr_addr = {2'd0, 8'($urandom_range(0, 95))};
        wr_data = 7'($urandom_range(0, 3) | ($urandom_range(0, 1) << 4) | ($urandom_range(0, 3) << 5));
      end else if (r == 1) begin
        wr_en = 1'b1; wr_addr = {2'd1, 8'($urandom_range(0, 95))}; wr_data = 7'($urandom_range(0, 3));
      end else if (r == 2) begin
        wr_en = 1'b1; wr_addr = {2'd2, 8'($urandom_range(0, 31))}; wr_data = 7'($urandom_range(0, 3));
      end else if (r == 3 || r == 4) begin
        int c = $urandom_range(0, 1);
        wr_en = 1'b1; wr_addr = {2'd3, 8'(last_ack[c])}; wr_data = 7'(c);
      end
      ack = 2'($urandom_range(0, 3) & $urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) spi[$urandom_range(0, 63)] ^= 1'b1;
      if ($urandom_range(0, 9) == 0) ppi[$urandom_range(0, 5)] ^= 1'b1;
      if ($urandom_range(0, 19) == 0) pl_fiq = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 19) == 0) pl_irq = 2'($urandom_range(0, 3));
      tick();
    end
    summary();
  end
endmodule